// File: doc/BRIEF.md
# Stop-Exit Sequencer and Operating-Mode Register

This block sits beside a processor core. It holds one control byte with four fields: a four-bit operating-mode field, an external-bus-disable bit, a stop-exit delay select and reserved bits. While reset is asserted, the mode field is loaded from four mode pins. After reset is released, software can overwrite the mode field. Software accesses the byte through a simple write strobe and a read bus that is always valid.

A stop request from the core drops the core-enable output. The output stays low until a wake event arrives. On the wake event a down-counter is loaded with either a long clock-stabilisation wait or a short wait, chosen by the delay-select bit at that moment. When the count has run out, core-enable is raised again.

While the bus-disable bit is set, external memory requests are refused: the block raises an error flag and issues no bus strobe.

Top module: `stopctl_top`

## Requirements
- R1: With bit 6 = 0 at the wake event, `core_en_o` is first seen high 131072 cycles after the clock edge that samples `wake_i`.
- R2: With bit 6 = 1 at the wake event, `core_en_o` is first seen high 16 cycles after the clock edge that samples `wake_i`.
- R3: A `stop_req_i` sampled while running drops `core_en_o` from the next cycle on. It stays low for as long as no wake event arrives.
- R4: Bits 7 and 5 of `reg_rdata_o` always read 0, whatever is written to them.
- R5: While bit 4 (bus disable) is 1, a sampled `ext_req_i` gives `ext_err_o` = 1 and `ext_strobe_o` = 0 in the next cycle.
- R6: While bit 4 is 0, a sampled `ext_req_i` gives `ext_strobe_o` = 1 and `ext_err_o` = 0 in the next cycle. With no request, both outputs are 0.
- R7: After reset, bit 4 = 0, bit 6 = 0, bits 3..0 equal `mode_pins_i` (pin 3 into bit 3 through pin 0 into bit 0), and `core_en_o` = 1.
- R8: After reset, a write replaces bits 6, 4 and 3..0 with the written data from the next cycle on. Changes on `mode_pins_i` then have no effect.
- R9: A write to bit 6 during a wake delay does not change the length of the delay already running.
- R10: `wake_i` while running, and `stop_req_i` or `wake_i` during a wake delay, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pins_i | input | 4 | Mode pins, captured during reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| stop_req_i | input | 1 | Stop request from the core |
| wake_i | input | 1 | Wake event |
| core_en_o | output | 1 | Instruction-cycle enable to the core |
| ext_req_i | input | 1 | External memory access request |
| ext_strobe_o | output | 1 | External bus strobe, one cycle after the request |
| ext_err_o | output | 1 | Access refused, one cycle after the request |
| op_mode_o | output | 4 | Current operating-mode field |

## Verification
The delay sequencer is exercised in several ways:
- plain stop/wake pairs with random idle gaps in the stopped state, which separate an indefinite hold from a timed release;
- stray stop and wake pulses injected during a delay, which show whether those inputs restart or shorten it;
- a delay-select write in the middle of a delay, which tells a delay latched at the wake event apart from one that tracks the register;
- one full long delay, which confirms the long count end to end.

Random register writes and random access requests, with the bus-disable bit in both states, separate the strobe path from the error path and show that the reserved bits stay zero.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;
  parameter int unsigned REG_W    = 8;
  parameter int unsigned MODE_W   = 4;
  parameter int unsigned EBD_BIT  = 4;
  parameter int unsigned SDLY_BIT = 6;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STOPPED = 2'd1,
    ST_WAKE    = 2'd2
  } stop_st_e;
endpackage

// File: rtl/stopctl_regs.sv
module stopctl_regs
  import stopctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_pins_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              sdly_o,
  output logic              ebd_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_q;
  logic              sdly_q, ebd_q;

  // mode field follows the pins while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= mode_pins_i;
      sdly_q <= 1'b0;
      ebd_q  <= 1'b0;
    end else if (we_i) begin
      mode_q <= wdata_i[MODE_W-1:0];
      sdly_q <= wdata_i[SDLY_BIT];
      ebd_q  <= wdata_i[EBD_BIT];
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[MODE_W-1:0]    = mode_q;
    rdata_o[EBD_BIT]       = ebd_q;
    rdata_o[SDLY_BIT]      = sdly_q;
  end

  assign sdly_o = sdly_q;
  assign ebd_o  = ebd_q;
  assign mode_o = mode_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o)) else $error("mode changed without write"); // R8
  AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_o == $past(wdata_i[MODE_W-1:0])) else $error("mode write lost"); // R8
endmodule

// File: rtl/stopctl_seq.sv
module stopctl_seq
  import stopctl_pkg::*;
#(
  parameter int unsigned LONG_DELAY  = 131072,
  parameter int unsigned SHORT_DELAY = 16,
  localparam int unsigned CNT_W      = $clog2(LONG_DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic wake_i,
  input  logic sdly_i,
  output logic core_en_o
);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_DELAY - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_DELAY - 1);

  stop_st_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN:     if (stop_req_i) state_d = ST_STOPPED;
      ST_STOPPED: if (wake_i) begin
        state_d = ST_WAKE;
        cnt_d   = sdly_i ? SHORT_LD : LONG_LD;
      end
      ST_WAKE: begin
        if (cnt_q == '0) state_d = ST_RUN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign core_en_o = (state_q == ST_RUN);

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOPPED && !wake_i) |=> !core_en_o) else $error("woke without event"); // R3
  AST_STOP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_o && stop_req_i) |=> !core_en_o) else $error("stop not taken"); // R3
  AST_CNT_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1 && !core_en_o))
    else $error("delay count skipped"); // R9
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && cnt_q == '0) |=> core_en_o) else $error("release missed"); // R1
  AST_WAKE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_o && !stop_req_i) |=> core_en_o) else $error("run left without stop"); // R10
endmodule

// File: rtl/stopctl_busgate.sv
module stopctl_busgate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ebd_i,
  input  logic req_i,
  output logic strobe_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      strobe_o <= req_i & ~ebd_i;
      err_o    <= req_i &  ebd_i;
    end
  end

  AST_NO_STROBE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ebd_i |=> !strobe_o) else $error("strobe while bus disabled"); // R5
  AST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_o && err_o)) else $error("strobe and error together"); // R6
  AST_REQ_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (strobe_o || err_o)) else $error("request unanswered"); // R6
endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
  import stopctl_pkg::*;
#(
  parameter int unsigned LONG_DELAY  = 131072,
  parameter int unsigned SHORT_DELAY = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_pins_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              stop_req_i,
  input  logic              wake_i,
  output logic              core_en_o,
  input  logic              ext_req_i,
  output logic              ext_strobe_o,
  output logic              ext_err_o,
  output logic [MODE_W-1:0] op_mode_o
);
  logic sdly, ebd;

  stopctl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_pins_i (mode_pins_i),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .sdly_o      (sdly),
    .ebd_o       (ebd),
    .mode_o      (op_mode_o)
  );

  stopctl_seq #(.LONG_DELAY(LONG_DELAY), .SHORT_DELAY(SHORT_DELAY)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .wake_i     (wake_i),
    .sdly_i     (sdly),
    .core_en_o  (core_en_o)
  );

  stopctl_busgate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ebd_i    (ebd),
    .req_i    (ext_req_i),
    .strobe_o (ext_strobe_o),
    .err_o    (ext_err_o)
  );
endmodule

// File: tb/stopctl_top_test.sv
`timescale 1ns/1ps
module stopctl_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'b1010;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       stop_req = 1'b0, wake = 1'b0, core_en;
  logic       ext_req = 1'b0, strobe, err;
  logic [3:0] op_mode;

  int checks = 0, fails = 0;
  logic [7:0] reg_m;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stopctl_top uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_pins_i(pins),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .stop_req_i(stop_req), .wake_i(wake), .core_en_o(core_en),
    .ext_req_i(ext_req), .ext_strobe_o(strobe), .ext_err_o(err),
    .op_mode_o(op_mode)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] w);
    return w & 8'h5F;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0;
    reg_m = exp_read(d);
  endtask

  task automatic access(input bit r);
    @(negedge clk); ext_req = r;
    @(posedge clk);
    @(negedge clk); ext_req = 1'b0;
    chk(strobe == (r & ~reg_m[4]), reg_m[4] ? "R5 strobe" : "R6 strobe", strobe, r & ~reg_m[4]);
    chk(err == (r & reg_m[4]), reg_m[4] ? "R5 err" : "R6 err", err, r & reg_m[4]);
  endtask

  task automatic stop_idle(input int gap);
    @(negedge clk); stop_req = 1'b1;
    @(posedge clk);
    @(negedge clk); stop_req = 1'b0;
    chk(core_en == 1'b0, "R3 stop entry", core_en, 0);
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < gap; i++) begin
        @(negedge clk);
        if (core_en) stayed = 1'b0;
      end
      chk(stayed, "R3 held while stopped", stayed, 1);
    end
  endtask

  // act: 0 none, 1 flip delay select, 2 stray stop, 3 stray wake (applied mid-delay)
  task automatic wake_measure(input int act, output int n);
    wake = 1'b1;
    @(posedge clk);
    @(negedge clk); wake = 1'b0;
    n = 0;
    while (!core_en && n < 200000) begin
      if (n == 3) begin
        case (act)
          1: begin we = 1'b1; wdata = reg_m ^ 8'h40; end
          2: stop_req = 1'b1;
          3: wake = 1'b1;
          default: ;
        endcase
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      if (we) reg_m = exp_read(wdata);
      we = 1'b0; stop_req = 1'b0; wake = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    chk(rdata == 8'h0A, "R7 mode capture in reset", rdata, 8'h0A);
    rst_n = 1'b1;
    reg_m = 8'h0A;
    @(negedge clk);
    chk(rdata == 8'h0A, "R7 reset value", rdata, 8'h0A);
    chk(core_en == 1'b1, "R7 core enabled", core_en, 1);
    chk(strobe == 1'b0 && err == 1'b0, "R7 bus idle", {strobe, err}, 0);
    pins = 4'b0101;
    repeat (3) @(negedge clk);
    chk(rdata == 8'h0A && op_mode == 4'hA, "R8 pins ignored after reset", rdata, 8'h0A);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr(d);
      chk(rdata == exp_read(d), "R4/R8 readback", rdata, exp_read(d));
      chk(rdata[7] == 1'b0 && rdata[5] == 1'b0, "R4 reserved zero", rdata, exp_read(d));
    end
    wr(8'hFF);
    chk(rdata == 8'h5F, "R4 all-ones write", rdata, 8'h5F);

    for (int i = 0; i < 40; i++) begin
      if (i % 8 == 0) wr((reg_m & 8'hEF) | (8'($urandom) & 8'h10));
      access(1'($urandom));
    end
    wr(8'h13); access(1'b1);
    wr(8'h03); access(1'b1); access(1'b0);

    // short delay cases
    wr(8'h43);
    @(negedge clk); wake = 1'b1;
    @(posedge clk);
    @(negedge clk); wake = 1'b0;
    chk(core_en == 1'b1, "R10 wake while running", core_en, 1);
    for (int i = 0; i < 6; i++) begin
      stop_idle(1 + int'($urandom % 20));
      wake_measure(0, n);
      chk(n == 16, "R2 short delay", n, 16);
    end
    stop_idle(500);
    wake_measure(0, n);
    chk(n == 16, "R2 after long idle", n, 16);
    stop_idle(4);
    wake_measure(2, n);
    chk(n == 16, "R10 stray stop in delay", n, 16);
    stop_idle(4);
    wake_measure(3, n);
    chk(n == 16, "R10 stray wake in delay", n, 16);
    stop_idle(4);
    wake_measure(1, n);
    chk(n == 16, "R9 select write mid-delay", n, 16);
    chk(rdata[6] == 1'b0, "R9 select written", rdata[6], 0);

    // long delay
    stop_idle(3);
    wake_measure(0, n);
    chk(n == 131072, "R1 long delay", n, 131072);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule